// File: doc/BRIEF.md
# Reduced-Power Mode Control Register

This block is one byte-wide special-function register that a CPU reaches over its internal register bus at address 87H, together with the logic that turns its contents into clock and pin controls. Software stops the CPU clock while peripherals keep running (light sleep) by setting one bit. Setting another bit stops the oscillator altogether (deep sleep). Two further bits double the serial baud rate and hold the address-latch-enable pin still. Two bits are free flags for software.

Light sleep ends when an enabled interrupt request arrives. The block then clears its own sleep bit so that execution resumes in the interrupt handler. Deep sleep ignores interrupts and register writes, and only a hardware reset ends it. Access is by whole byte only. Reads return the register image when the address matches and zero otherwise.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the register reads 00H and cpuClkGate, oscStop, baudDouble and aleHold are all 0.
- R2: A write with sfrWrEn=1 and sfrAddr=87H stores the byte at that clock edge. Bits 7, 5, 3, 2, 1 and 0 are kept, and bits 6 and 4 always read 0, so the readback is data AND AFH.
- R3: Writes to any other address leave the register unchanged, and a read at any other address returns 00H.
- R4: Bit 0 set to 1 with bit 1 at 0 drives cpuClkGate=1 and oscStop=0 from the edge that stores the write.
- R5: While bit 0 is 1 and bit 1 is 0, irqPending=1 clears bit 0 at the next edge, and cpuClkGate returns to 0.
- R6: irqPending has no effect on the register or the outputs when bit 0 is 0.
- R7: Bit 1 set to 1 (alone or together with bit 0) drives oscStop=1 and cpuClkGate=1, and irqPending does not release it.
- R8: While bit 1 is 1, writes are ignored. Only reset clears it.
- R9: baudDouble equals bit 7 and aleHold equals bit 5. Bits 3 and 2 are storage only and drive no output.
- R10: When a register write and a wake request fall in the same cycle, the written byte is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| sfrAddr | input | 8 | Register bus address |
| sfrWrEn | input | 1 | Write strobe for the register bus |
| sfrWrData | input | 8 | Write data |
| sfrRdData | output | 8 | Read data (register image at 87H, otherwise 0) |
| irqPending | input | 1 | An enabled interrupt request is pending |
| cpuClkGate | output | 1 | 1 stops the CPU clock |
| oscStop | output | 1 | 1 stops the oscillator |
| baudDouble | output | 1 | Serial baud-rate doubling |
| aleHold | output | 1 | 1 keeps the address-latch-enable pin from toggling |

## Verification
Two functions can act on the light-sleep bit in the same cycle: a bus write to 87H and the wake caused by a pending interrupt. The bench holds the block in light sleep, then drives a write and irqPending together on one clock. The readback must equal the written byte rather than that byte with bit 0 cleared. A second case puts the block in deep sleep, then applies an interrupt and a write together. Neither may release the oscillator stop.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int SFR_W = 8;
  localparam int BIT_BAUD = 7;
  localparam int BIT_ALE = 5;
  localparam int BIT_DEEP = 1;
  localparam int BIT_LIGHT = 0;
  localparam logic [SFR_W-1:0] KEEP_MASK = 8'hAF;

  typedef struct packed {
    logic loadReg;
    logic wakeIdle;
  } ctlStrobe_t;

  typedef struct packed {
    logic baud;
    logic ale;
    logic deep;
    logic light;
  } modeBits_t;
endpackage

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [SFR_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [SFR_W-1:0]  rdData,
  output modeBits_t         modeBits
);
  logic [SFR_W-1:0] regQ;

  // One flop per kept bit, reserved positions tied low
  for (genvar i = 0; i < SFR_W; i++) begin : g_bit
    if (KEEP_MASK[i]) begin : g_kept
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regQ[i] <= 1'b0;
        else if (strobe.loadReg)
          regQ[i] <= wrData[i];
        else if (strobe.wakeIdle && i == BIT_LIGHT)
          regQ[i] <= 1'b0;
      end
    end else begin : g_resv
      assign regQ[i] = 1'b0;
    end
  end

  assign rdData = (rdAddr == REG_ADDR) ? regQ : '0;

  assign modeBits.baud  = regQ[BIT_BAUD];
  assign modeBits.ale   = regQ[BIT_ALE];
  assign modeBits.deep  = regQ[BIT_DEEP];
  assign modeBits.light = regQ[BIT_LIGHT];
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic              irqPending,
  input  modeBits_t         modeBits,
  output ctlStrobe_t        strobe,
  output logic              cpuClkGate,
  output logic              oscStop,
  output logic              baudDouble,
  output logic              aleHold
);
  logic addrHit;

  always_comb begin
    addrHit = (sfrAddr == REG_ADDR);
    // Deep sleep freezes the register until reset
    strobe.loadReg  = sfrWrEn && addrHit && !modeBits.deep;
    // Wake only from light sleep; a same-cycle write overrides it
    strobe.wakeIdle = irqPending && modeBits.light && !modeBits.deep;
    oscStop    = modeBits.deep;
    cpuClkGate = modeBits.deep | modeBits.light;
    baudDouble = modeBits.baud;
    aleHold    = modeBits.ale;
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic [SFR_W-1:0]  sfrWrData,
  output logic [SFR_W-1:0]  sfrRdData,
  input  logic              irqPending,
  output logic              cpuClkGate,
  output logic              oscStop,
  output logic              baudDouble,
  output logic              aleHold
);
  ctlStrobe_t strobe;
  modeBits_t  modeBits;

  pwr_mode_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_ctrl (
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .irqPending(irqPending),
    .modeBits(modeBits), .strobe(strobe), .cpuClkGate(cpuClkGate),
    .oscStop(oscStop), .baudDouble(baudDouble), .aleHold(aleHold)
  );

  pwr_mode_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(sfrWrData),
    .rdAddr(sfrAddr), .rdData(sfrRdData), .modeBits(modeBits)
  );
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] sfrAddr,
  input logic              sfrWrEn,
  input logic [SFR_W-1:0]  sfrWrData,
  input logic              irqPending,
  input logic              cpuClkGate,
  input logic              oscStop,
  input logic              baudDouble,
  input logic              aleHold
);
  assert_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sfrWrEn && sfrAddr == REG_ADDR && !oscStop)
      |=> (baudDouble == $past(sfrWrData[BIT_BAUD]) && aleHold == $past(sfrWrData[BIT_ALE])));

  assert_other_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sfrAddr != REG_ADDR && !irqPending)
      |=> $stable({baudDouble, aleHold, oscStop, cpuClkGate}));

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkGate && !oscStop && irqPending && !(sfrWrEn && sfrAddr == REG_ADDR))
      |=> !cpuClkGate);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkGate && !(sfrWrEn && sfrAddr == REG_ADDR)) |=> !cpuClkGate);

  assert_deep_gates_R7: assert property (@(posedge clk) disable iff (!rstN)
    oscStop |-> cpuClkGate);

  assert_deep_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    oscStop |=> (oscStop && $stable({baudDouble, aleHold})));
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_chk (
  .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
  .sfrWrData(sfrWrData), .irqPending(irqPending), .cpuClkGate(cpuClkGate),
  .oscStop(oscStop), .baudDouble(baudDouble), .aleHold(aleHold)
);

// File: tb/test_pwr_mode_ctl.sv
module test_pwr_mode_ctl;
  localparam logic [7:0] REG = 8'h87;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic sfrWrEn = 1'b0;
  logic [7:0] sfrWrData = 8'h00;
  logic [7:0] sfrRdData;
  logic irqPending = 1'b0;
  logic cpuClkGate, oscStop, baudDouble, aleHold;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctl i_pwr_mode_ctl (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .irqPending(irqPending),
    .cpuClkGate(cpuClkGate), .oscStop(oscStop), .baudDouble(baudDouble),
    .aleHold(aleHold)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    sfrWrEn = 1'b0; irqPending = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Drive at a falling edge, store at the rising edge, return at the next falling edge
  task automatic wrReg(input logic [7:0] a, input logic [7:0] d, input logic irq);
    @(negedge clk);
    sfrAddr = a; sfrWrData = d; sfrWrEn = 1'b1; irqPending = irq;
    @(negedge clk);
    sfrWrEn = 1'b0; irqPending = 1'b0; sfrAddr = REG;
  endtask

  task automatic pulseIrq();
    @(negedge clk) irqPending = 1'b1;
    @(negedge clk) irqPending = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {4'b0, cpuClkGate, oscStop, baudDouble, aleHold};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    sfrAddr = REG;
    #1;
    check("R1 read", sfrRdData, 8'h00);
    check("R1 outputs", outs(), 8'h00);

    // R2 R4 R9: sweep every byte with bit 1 clear
    for (int d = 0; d < 256; d++) begin
      if (d[1]) continue;
      wrReg(REG, 8'(d), 1'b0);
      check("R2 readback", sfrRdData, 8'(d) & 8'hAF);
      check("R4 R9 outputs", outs(),
            {4'b0, d[0] ? 1'b1 : 1'b0, 1'b0, d[7] ? 1'b1 : 1'b0, d[5] ? 1'b1 : 1'b0});
    end

    // R3: other addresses ignore writes and read zero
    wrReg(REG, 8'hA0, 1'b0);
    for (int a = 0; a < 256; a++) begin
      if (a == 32'h87) continue;
      wrReg(8'(a), 8'hFF, 1'b0);
      sfrAddr = 8'(a); #1;
      check("R3 foreign read", sfrRdData, 8'h00);
      sfrAddr = REG; #1;
      check("R3 reg unchanged", sfrRdData, 8'hA0);
    end

    // R6: interrupt with light sleep off
    wrReg(REG, 8'h2C, 1'b0);
    pulseIrq();
    check("R6 reg", sfrRdData, 8'h2C);
    check("R6 outputs", outs(), 8'h01);

    // R5: wake from light sleep
    wrReg(REG, 8'h8D, 1'b0);
    check("R4 gate on", outs(), 8'h0A);
    pulseIrq();
    check("R5 bit cleared", sfrRdData, 8'h8C);
    check("R5 gate off", outs(), 8'h02);

    // R10: write and wake in the same cycle
    wrReg(REG, 8'h01, 1'b0);
    wrReg(REG, 8'h05, 1'b1);
    check("R10 write wins", sfrRdData, 8'h05);
    check("R10 gate", outs(), 8'h08);

    // R7 R8: both sleep bits together
    wrReg(REG, 8'hA3, 1'b0);
    check("R7 outputs", outs(), 8'h0F);
    pulseIrq();
    check("R7 irq ignored", outs(), 8'h0F);
    wrReg(REG, 8'h00, 1'b1);
    check("R8 write ignored", sfrRdData, 8'hA3);
    check("R8 still deep", outs(), 8'h0F);
    repeat (20) @(negedge clk);
    check("R8 holds", outs(), 8'h0F);
    doReset();
    sfrAddr = REG; #1;
    check("R8 reset exits", sfrRdData, 8'h00);
    check("R8 reset outputs", outs(), 8'h00);

    // R7: deep sleep alone
    wrReg(REG, 8'h02, 1'b0);
    check("R7 deep alone", outs(), 8'h0C);
    doReset();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule